// File: doc/BRIEF.md
# Flash Code-Protection Access Gate

This block sits between the three request paths that reach the on-chip flash and the flash controller. It decides, for every request, whether the flash is allowed to act on it. The three paths are the debug port, the serial boot-loader command path and the in-application programming path. The decision is based on a protection word read from a reserved flash location. That word selects one of four tiers: open, tier 1, tier 2 or tier 3.

The word is captured once, on the first clock after reset is released. Until then the gate behaves as the strictest tier. In-application requests are never restricted.

- At tier 1, the boot loader may program or erase single sectors other than sector 0.
- At tier 2, the boot loader may only erase the whole device, and may program only after such an erase.
- At tier 3, the boot loader and the debug port are locked out, and the boot-override pin is ignored.

Each request receives its grant or deny exactly one cycle after it is presented. The block also drives a debug-enable level and a boot-override-enable level for the neighbouring logic.

Top module: `fcg_access_gate`

## Requirements
- R1: Decoding of the protection word:
  - The word `WORD_L1` selects tier 1, `WORD_L2` selects tier 2 and `WORD_L3` selects tier 3.
  - `WORD_NONE`, and every other value, selects open.
- R2: The word is captured on the first rising edge after reset release. Later changes of `prot_word` have no effect until the next reset.
- R3: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. `rsp_grant` is high only together with `rsp_valid`.
- R4: A request with origin 2 (in-application) is granted at every tier, for every kind and sector.
- R5: A request with origin 0 (debug) is granted only at open. `dbg_enable` is high exactly when the tier is open.
- R6: At tier 1, boot-loader requests (origin 1) behave as follows:
  - Kind 1 (program) and kind 2 (sector erase) are granted when `req_sector` is not 0.
  - Sector 0, kind 0 (read) and kind 3 (device erase) are denied.
- R7: At tier 2, boot-loader requests behave as follows:
  - Kind 3 is granted.
  - Kinds 0 and 2 are denied.
  - Kind 1 is granted only once some device erase has been granted since reset; that erase takes effect from the following request onward.
- R8: At tier 3, every boot-loader request is denied and `boot_ovr_enable` stays low whatever `boot_pin` does.
- R9: At open and at tiers 1 and 2, `boot_ovr_enable` equals `boot_pin` in the same cycle.
- R10: At open, boot-loader requests of every kind are granted.
- R11: A request with origin 3 (no defined source) is always denied.
- R12: While reset is asserted, `rsp_valid`, `rsp_grant`, `dbg_enable` and `boot_ovr_enable` are all low. The gate acts as tier 3 until the word has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_word | input | PROT_W (32) | Protection word from the reserved flash location |
| req_valid | input | 1 | Request present this cycle |
| req_origin | input | 2 | 0 debug, 1 boot loader, 2 in-application |
| req_kind | input | 2 | 0 read, 1 program, 2 sector erase, 3 device erase |
| req_sector | input | SECTOR_W (5) | Target sector of the request |
| boot_pin | input | 1 | Sampled boot-override pin |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_grant | output | 1 | 1 grant, 0 deny (meaningful with rsp_valid) |
| dbg_enable | output | 1 | Debug port allowed |
| boot_ovr_enable | output | 1 | Boot-override pin honoured |

## Verification
The bench goes after the following corner cases, and describes what a design that got each one wrong would do:
- **Sector 0 at tier 1.** A gate that checked only the request kind would grant a sector-0 program.
- **Program before erase at tier 2.** A gate without the sticky erase record would grant programming before any device erase. One that set the record a cycle late would deny a program that immediately follows the erase.
- **Changing the word after capture.** A gate that kept following `prot_word` would unlock debug when the word changes after capture.
- **Boot pin at tier 3.** A gate that ignored the tier for `boot_pin` would raise the override at tier 3.
- **Requests before capture.** A reset value other than the strictest tier would leak grants or debug-enable before the word is captured.

A random run across all four tiers, all origins and all kinds is compared against the reference model on every clock.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN  = 2'd0,
    LVL_ONE   = 2'd1,
    LVL_TWO   = 2'd2,
    LVL_THREE = 2'd3
  } prot_lvl_t;

  localparam logic [1:0] SRC_DEBUG = 2'd0;
  localparam logic [1:0] SRC_BOOT  = 2'd1;
  localparam logic [1:0] SRC_IAP   = 2'd2;

  localparam logic [1:0] OP_READ       = 2'd0;
  localparam logic [1:0] OP_PROG       = 2'd1;
  localparam logic [1:0] OP_SECT_ERASE = 2'd2;
  localparam logic [1:0] OP_DEV_ERASE  = 2'd3;

endpackage

// File: rtl/fcg_level_latch.sv
module fcg_level_latch
  import fcg_pkg::*;
#(
  parameter int unsigned PROT_W = 32,
  parameter logic [PROT_W-1:0] WORD_NONE = '1,
  parameter logic [PROT_W-1:0] WORD_L1 = '0,
  parameter logic [PROT_W-1:0] WORD_L2 = '0,
  parameter logic [PROT_W-1:0] WORD_L3 = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PROT_W-1:0] prot_word,
  output prot_lvl_t         level
);

  logic      cap_q, cap_d;
  prot_lvl_t level_q, level_d;
  prot_lvl_t decoded;

  // Unknown patterns fall through to open.
  always_comb begin
    if (prot_word == WORD_L3)        decoded = LVL_THREE;
    else if (prot_word == WORD_L2)   decoded = LVL_TWO;
    else if (prot_word == WORD_L1)   decoded = LVL_ONE;
    else if (prot_word == WORD_NONE) decoded = LVL_OPEN;
    else                             decoded = LVL_OPEN;
  end

  always_comb begin
    cap_d   = cap_q;
    level_d = level_q;
    if (!cap_q) begin
      cap_d   = 1'b1;
      level_d = decoded;
    end
  end

  // Strictest tier until the word has been taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      level_q <= LVL_THREE;
    end else begin
      cap_q   <= cap_d;
      level_q <= level_d;
    end
  end

  assign level = level_q;

  // R2
  level_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> $stable(level_q));

endmodule

// File: rtl/fcg_policy.sv
module fcg_policy
  import fcg_pkg::*;
#(
  parameter int unsigned SECTOR_W = 5
) (
  input  prot_lvl_t           level,
  input  logic                erased,
  input  logic [1:0]          origin,
  input  logic [1:0]          kind,
  input  logic [SECTOR_W-1:0] sector,
  output logic                allow
);

  logic boot_allow;
  logic not_sec0;

  assign not_sec0 = (sector != '0);

  always_comb begin
    unique case (level)
      LVL_OPEN:  boot_allow = 1'b1;
      LVL_ONE:   boot_allow = not_sec0 && (kind == OP_PROG || kind == OP_SECT_ERASE);
      LVL_TWO:   boot_allow = (kind == OP_DEV_ERASE) || (kind == OP_PROG && erased);
      default:   boot_allow = 1'b0;
    endcase
  end

  always_comb begin
    unique case (origin)
      SRC_IAP:   allow = 1'b1;
      SRC_DEBUG: allow = (level == LVL_OPEN);
      SRC_BOOT:  allow = boot_allow;
      default:   allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/fcg_access_gate.sv
module fcg_access_gate
  import fcg_pkg::*;
#(
  parameter int unsigned PROT_W   = 32,
  parameter int unsigned SECTOR_W = 5,
  parameter logic [PROT_W-1:0] WORD_NONE = 32'hFFFF_FFFF,
  parameter logic [PROT_W-1:0] WORD_L1   = 32'h5A3C_0001,
  parameter logic [PROT_W-1:0] WORD_L2   = 32'hA5C3_0002,
  parameter logic [PROT_W-1:0] WORD_L3   = 32'h3C5A_0003
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PROT_W-1:0]   prot_word,
  input  logic                req_valid,
  input  logic [1:0]          req_origin,
  input  logic [1:0]          req_kind,
  input  logic [SECTOR_W-1:0] req_sector,
  input  logic                boot_pin,
  output logic                rsp_valid,
  output logic                rsp_grant,
  output logic                dbg_enable,
  output logic                boot_ovr_enable
);

  prot_lvl_t level;
  logic      allow;
  logic      erased_q, erased_d;
  logic      rsp_valid_q, rsp_valid_d;
  logic      rsp_grant_q, rsp_grant_d;

  fcg_level_latch #(
    .PROT_W   (PROT_W),
    .WORD_NONE(WORD_NONE),
    .WORD_L1  (WORD_L1),
    .WORD_L2  (WORD_L2),
    .WORD_L3  (WORD_L3)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .prot_word(prot_word),
    .level    (level)
  );

  fcg_policy #(.SECTOR_W(SECTOR_W)) u_policy (
    .level (level),
    .erased(erased_q),
    .origin(req_origin),
    .kind  (req_kind),
    .sector(req_sector),
    .allow (allow)
  );

  always_comb begin
    erased_d    = erased_q;
    rsp_valid_d = req_valid;
    rsp_grant_d = 1'b0;
    if (req_valid) begin
      rsp_grant_d = allow;
      if (allow && req_kind == OP_DEV_ERASE) erased_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erased_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_grant_q <= 1'b0;
    end else begin
      erased_q    <= erased_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_grant_q <= rsp_grant_d;
    end
  end

  assign rsp_valid       = rsp_valid_q;
  assign rsp_grant       = rsp_grant_q;
  assign dbg_enable      = (level == LVL_OPEN);
  assign boot_ovr_enable = boot_pin && (level != LVL_THREE);

  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R3
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3
  grant_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> rsp_valid);
  // R4
  iap_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_origin == SRC_IAP) |=> rsp_grant);
  // R5
  debug_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_origin == SRC_DEBUG && !dbg_enable) |=> !rsp_grant);
  // R7
  prog_needs_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && level == LVL_TWO && req_origin == SRC_BOOT &&
     req_kind == OP_PROG && !erased_q) |=> !rsp_grant);
  // R8
  override_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_origin == SRC_BOOT && boot_pin && !boot_ovr_enable) |=> !rsp_grant);

endmodule

// File: tb/fcg_access_gate_test.sv
module fcg_access_gate_test;

  localparam logic [31:0] W_NONE = 32'hFFFF_FFFF;
  localparam logic [31:0] W_L1   = 32'h5A3C_0001;
  localparam logic [31:0] W_L2   = 32'hA5C3_0002;
  localparam logic [31:0] W_L3   = 32'h3C5A_0003;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] prot_word;
  logic        req_valid;
  logic [1:0]  req_origin;
  logic [1:0]  req_kind;
  logic [4:0]  req_sector;
  logic        boot_pin;
  logic        rsp_valid, rsp_grant, dbg_enable, boot_ovr_enable;

  int vectors = 0;
  int miscompares = 0;

  int m_lvl;
  bit m_cap;
  bit m_erased;

  always #2 clk = ~clk;

  fcg_access_gate #(
    .PROT_W(32), .SECTOR_W(5),
    .WORD_NONE(W_NONE), .WORD_L1(W_L1), .WORD_L2(W_L2), .WORD_L3(W_L3)
  ) uut (
    .clk(clk), .rst_n(rst_n), .prot_word(prot_word),
    .req_valid(req_valid), .req_origin(req_origin), .req_kind(req_kind),
    .req_sector(req_sector), .boot_pin(boot_pin),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .dbg_enable(dbg_enable), .boot_ovr_enable(boot_ovr_enable)
  );

  function automatic int decode(input logic [31:0] w);
    if (w == W_L1) return 1;
    if (w == W_L2) return 2;
    if (w == W_L3) return 3;
    return 0;
  endfunction

  function automatic bit permitted(input int lvl, input bit er, input int o, input int k, input int s);
    if (o == 2) return 1;
    if (o == 0) return lvl == 0;
    if (o == 3) return 0;
    case (lvl)
      0: return 1;
      1: return (s != 0) && (k == 1 || k == 2);
      2: return (k == 3) || (k == 1 && er);
      default: return 0;
    endcase
  endfunction

  function automatic string auto_tag(input int lvl, input int o);
    if (o == 2) return "R4";
    if (o == 3) return "R11";
    if (o == 0) return "R5";
    case (lvl)
      0: return "R10";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [31:0] w);
    @(negedge clk);
    rst_n = 1'b0; prot_word = w; req_valid = 1'b0; req_origin = 2'd0;
    req_kind = 2'd0; req_sector = 5'd0; boot_pin = 1'b1;
    repeat (2) @(negedge clk);
    // R12: outputs quiet and strictest tier during reset
    check("R12", "rsp_valid", rsp_valid, 1'b0);
    check("R12", "rsp_grant", rsp_grant, 1'b0);
    check("R12", "dbg_enable", dbg_enable, 1'b0);
    check("R12", "boot_ovr_enable", boot_ovr_enable, 1'b0);
    m_lvl = 3; m_cap = 0; m_erased = 0;
    rst_n = 1'b1;
  endtask

  // Called at a negedge; returns at the next negedge after comparing.
  task automatic step(input logic v, input logic [1:0] o, input logic [1:0] k,
                      input logic [4:0] s, input logic pin, input string tag_in);
    logic  exp_v, exp_g;
    string tag;
    req_valid = v; req_origin = o; req_kind = k; req_sector = s; boot_pin = pin;
    tag = (tag_in == "") ? auto_tag(m_lvl, int'(o)) : tag_in;
    exp_v = v;
    exp_g = v && permitted(m_lvl, m_erased, int'(o), int'(k), int'(s));
    if (exp_g && k == 2'd3) m_erased = 1;
    if (!m_cap) begin m_lvl = decode(prot_word); m_cap = 1; end
    @(posedge clk);
    @(negedge clk);
    check("R3", "rsp_valid", rsp_valid, exp_v);
    check(tag, "rsp_grant", rsp_grant, exp_g);
    check("R5", "dbg_enable", dbg_enable, m_lvl == 0);
    check(m_lvl == 3 ? "R8" : "R9", "boot_ovr_enable", boot_ovr_enable, pin && (m_lvl != 3));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prot_word = W_NONE; req_valid = 1'b0; req_origin = 2'd0;
    req_kind = 2'd0; req_sector = 5'd0; boot_pin = 1'b0;

    // Open tier
    do_reset(W_NONE);
    step(0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 3, 0, "R5");
    for (int k = 0; k < 4; k++) step(1, 1, 2'(k), 0, 0, "R10");
    step(1, 3, 1, 4, 0, "R11");
    step(1, 2, 0, 0, 1, "R4");
    step(0, 0, 0, 0, 1, "R9");

    // Unknown word decodes as open
    do_reset(32'h1234_5678);
    step(0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, "R1");

    // Tier 1
    do_reset(W_L1);
    step(0, 0, 0, 0, 1, "R9");
    step(1, 0, 0, 2, 0, "R5");
    step(1, 1, 0, 5, 0, "R6");
    step(1, 1, 1, 0, 0, "R6");
    step(1, 1, 1, 3, 0, "R6");
    step(1, 1, 2, 0, 0, "R6");
    step(1, 1, 2, 7, 0, "R6");
    step(1, 1, 3, 9, 0, "R6");
    step(1, 2, 1, 0, 0, "R4");
    // R2: a later change of the word must not unlock anything
    prot_word = W_NONE;
    step(1, 0, 0, 1, 0, "R2");
    step(1, 1, 1, 0, 0, "R2");

    // Tier 2
    do_reset(W_L2);
    step(0, 0, 0, 0, 0, "R7");
    step(1, 1, 1, 4, 0, "R7");
    step(1, 1, 0, 4, 0, "R7");
    step(1, 1, 2, 4, 0, "R7");
    step(1, 1, 3, 0, 0, "R7");
    step(1, 1, 1, 4, 0, "R7");
    step(1, 1, 1, 0, 1, "R7");
    step(1, 0, 0, 0, 1, "R5");

    // Tier 3
    do_reset(W_L3);
    step(0, 0, 0, 0, 1, "R8");
    for (int k = 0; k < 4; k++) step(1, 1, 2'(k), 5'd6, 1, "R8");
    step(1, 2, 3, 0, 1, "R4");
    step(1, 0, 0, 0, 1, "R5");

    // Random traffic across tiers
    for (int p = 0; p < 8; p++) begin
      int pick;
      logic [31:0] w;
      pick = $urandom_range(0, 4);
      case (pick)
        0: w = W_NONE;
        1: w = W_L1;
        2: w = W_L2;
        3: w = W_L3;
        default: w = $urandom;
      endcase
      do_reset(w);
      for (int i = 0; i < 60; i++) begin
        if (i == 30) prot_word = $urandom;
        step(1'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
             5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule